// File: doc/BRIEF.md
# Host Cycle Address Decoder

This block decides, for every host I/O or memory cycle, whether the cycle belongs to the downstream serial peripheral bus. It checks three kinds of decode. The first is a small set of fixed legacy ports. The second is a parameterized bank of programmable I/O windows. The third is a bank of programmable memory windows. Every decode has its own bit in one decode-enable register. An optional subtractive mode claims any cycle that no positive decode claims.

Configuration uses a simple word-wide register write port and a combinational read port. The lookup port is purely combinational. It takes the cycle address, the cycle kind (I/O or memory) and the access length in bytes. It returns a forward flag, the decode kind and the index of the decode that won. Cycle forwarding, the bus protocol and upstream arbitration belong to other blocks.

Register map (byte offsets on `cfg_addr_i`):
- 0x00 holds the decode enables. A write to 0x00 replaces the whole register.
- 0x04 is a set port. A write there ORs the data into the enables.
- 0x08 holds the subtractive enable in bit 0.
- 0x40+4·i holds I/O window i, with the base in [15:0] and the size field in [23:16].
- 0x80+8·j holds the base of memory window j.
- 0x84+8·j holds the size field of memory window j in [15:0].

Enable bit positions:
- Bit 0 enables port 0x80.
- Bit 1 enables ports 0x60 and 0x64.
- Bit 2 enables ports 0x2E and 0x2F.
- Bits 8+i enable I/O window i.
- Bits 16+j enable memory window j.

Top module: `host_cycle_decoder`

## Requirements
- R1: After reset every register reads zero and no lookup is forwarded (`fwd_o`=0, `kind_o`=0, `idx_o`=0).
- R2: The fixed decodes apply to I/O cycles only, and each hits only for the listed accesses. Enable bit 0 covers port 0x80 with length 1 and reports index 0. Enable bit 1 covers port 0x60 or 0x64 with length 1 and reports index 1. Enable bit 2 covers port 0x2E or 0x2F with length 1, or 0x2E with length 2, and reports index 2. A fixed hit gives kind 1.
- R3: I/O window i hits an I/O cycle when address[31:16]=0 and base ≤ address[15:0] ≤ base + size field, with the sum taken without wrapping past 0xFFFF. A hit gives kind 2 and index i.
- R4: A window whose enable bit is clear never hits, whatever its base and size.
- R5: Memory window j hits a memory cycle when base ≤ address ≤ base + size field, with no wrap past 0xFFFFFFFF. A hit gives kind 3 and index j. I/O windows never hit memory cycles.
- R6: Writing zero to offset 0x00 disables every decode in one write, and leaves the base and size registers unchanged.
- R7: A write to offset 0x04 ORs its data into the enables, so bits already set stay set.
- R8: A fixed decode hit wins over any I/O window. Among matching windows of the same kind, the lowest index is reported.
- R9: When subtractive mode is on, an unclaimed cycle is forwarded with kind 4 and index 0. When it is off, an unclaimed cycle gives `fwd_o`=0 and kind 0.
- R10: Every register reads back what was written, masked to its implemented bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Register byte offset |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Register read data for `cfg_addr_i` |
| lk_addr_i | input | 32 | Cycle address |
| lk_mem_i | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| lk_len_i | input | 3 | Access length in bytes |
| fwd_o | output | 1 | Cycle is forwarded downstream |
| kind_o | output | 3 | 0 none, 1 fixed, 2 I/O window, 3 memory window, 4 subtractive |
| idx_o | output | IDXW | Index of the winning decode |

## Verification
Some properties are checked on every cycle:
- An I/O window is reported only when its enable bit is set.
- No lower-index I/O window matched when a higher one is reported.
- A fixed hit never comes from a memory cycle.
- The subtractive kind never appears with the mode off.
- A zero write to the enables clears them, and a set-port write never drops a bit.

The scenarios are what show the window edges:
- the exact byte just inside and just outside each window;
- the refusal to wrap at the top of the I/O and memory spaces;
- the exact-length rule of the legacy ports;
- that clearing the enables leaves base and size registers untouched.

// File: rtl/hcd_pkg.sv
package hcd_pkg;
  typedef enum logic [2:0] {
    HK_NONE  = 3'd0,
    HK_FIXED = 3'd1,
    HK_IO    = 3'd2,
    HK_MEM   = 3'd3,
    HK_SUB   = 3'd4
  } hit_kind_e;

  localparam logic [7:0] OFF_EN     = 8'h00;
  localparam logic [7:0] OFF_EN_SET = 8'h04;
  localparam logic [7:0] OFF_CTRL   = 8'h08;
  localparam logic [7:0] OFF_IO     = 8'h40;
  localparam logic [7:0] OFF_MEM    = 8'h80;

  localparam int EN_IO_LSB  = 8;
  localparam int EN_MEM_LSB = 16;
endpackage

// File: rtl/hcd_window_match.sv
module hcd_window_match #(
  parameter int AW = 16,
  parameter int SW = 8
) (
  input  logic          en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] base_i,
  input  logic [SW-1:0] size_i,
  output logic          hit_o
);
  // one extra bit so base + size never wraps
  logic [AW:0] last;
  assign last  = {1'b0, base_i} + {{(AW+1-SW){1'b0}}, size_i};
  assign hit_o = en_i && (addr_i >= base_i) && ({1'b0, addr_i} <= last);
endmodule

// File: rtl/hcd_lowest_pick.sv
module hcd_lowest_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/hcd_legacy_decode.sv
module hcd_legacy_decode (
  input  logic        io_i,
  input  logic [15:0] addr_i,
  input  logic [2:0]  len_i,
  input  logic [2:0]  en_i,
  output logic        hit_o,
  output logic [1:0]  idx_o
);
  logic p80, kbc, sio;
  assign p80 = en_i[0] && len_i == 3'd1 && addr_i == 16'h0080;
  assign kbc = en_i[1] && len_i == 3'd1 && (addr_i == 16'h0060 || addr_i == 16'h0064);
  assign sio = en_i[2] && ((len_i == 3'd1 && (addr_i == 16'h002E || addr_i == 16'h002F)) ||
                           (len_i == 3'd2 && addr_i == 16'h002E));
  assign hit_o = io_i && (p80 || kbc || sio);
  assign idx_o = p80 ? 2'd0 : kbc ? 2'd1 : 2'd2;
endmodule

// File: rtl/host_cycle_decoder.sv
module host_cycle_decoder
  import hcd_pkg::*;
#(
  parameter int NIO  = 4,
  parameter int NMEM = 4,
  parameter int NMAX = (NIO > NMEM) ? NIO : NMEM,
  parameter int IDXW = (NMAX > 4) ? $clog2(NMAX) : 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cfg_we_i,
  input  logic [7:0]      cfg_addr_i,
  input  logic [31:0]     cfg_wdata_i,
  output logic [31:0]     cfg_rdata_o,
  input  logic [31:0]     lk_addr_i,
  input  logic            lk_mem_i,
  input  logic [2:0]      lk_len_i,
  output logic            fwd_o,
  output logic [2:0]      kind_o,
  output logic [IDXW-1:0] idx_o
);
  localparam logic [31:0] IO_EN_MASK  = ((32'd1 << NIO) - 32'd1) << EN_IO_LSB;
  localparam logic [31:0] MEM_EN_MASK = ((32'd1 << NMEM) - 32'd1) << EN_MEM_LSB;
  localparam logic [31:0] EN_MASK     = 32'h7 | IO_EN_MASK | MEM_EN_MASK;

  logic [31:0] en_q;
  logic        sub_q;
  logic [15:0] io_base_q  [NIO];
  logic [7:0]  io_size_q  [NIO];
  logic [31:0] mem_base_q [NMEM];
  logic [15:0] mem_size_q [NMEM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      sub_q <= 1'b0;
      for (int i = 0; i < NIO; i++) begin
        io_base_q[i] <= '0;
        io_size_q[i] <= '0;
      end
      for (int j = 0; j < NMEM; j++) begin
        mem_base_q[j] <= '0;
        mem_size_q[j] <= '0;
      end
    end else if (cfg_we_i) begin
      if (cfg_addr_i == OFF_EN)     en_q  <= cfg_wdata_i & EN_MASK;
      if (cfg_addr_i == OFF_EN_SET) en_q  <= en_q | (cfg_wdata_i & EN_MASK);
      if (cfg_addr_i == OFF_CTRL)   sub_q <= cfg_wdata_i[0];
      for (int i = 0; i < NIO; i++) begin
        if (cfg_addr_i == OFF_IO + 8'(4 * i)) begin
          io_base_q[i] <= cfg_wdata_i[15:0];
          io_size_q[i] <= cfg_wdata_i[23:16];
        end
      end
      for (int j = 0; j < NMEM; j++) begin
        if (cfg_addr_i == OFF_MEM + 8'(8 * j))     mem_base_q[j] <= cfg_wdata_i;
        if (cfg_addr_i == OFF_MEM + 8'(8 * j + 4)) mem_size_q[j] <= cfg_wdata_i[15:0];
      end
    end
  end

  always_comb begin
    cfg_rdata_o = '0;
    if (cfg_addr_i == OFF_EN)   cfg_rdata_o = en_q;
    if (cfg_addr_i == OFF_CTRL) cfg_rdata_o = {31'd0, sub_q};
    for (int i = 0; i < NIO; i++)
      if (cfg_addr_i == OFF_IO + 8'(4 * i))
        cfg_rdata_o = {8'd0, io_size_q[i], io_base_q[i]};
    for (int j = 0; j < NMEM; j++) begin
      if (cfg_addr_i == OFF_MEM + 8'(8 * j))     cfg_rdata_o = mem_base_q[j];
      if (cfg_addr_i == OFF_MEM + 8'(8 * j + 4)) cfg_rdata_o = {16'd0, mem_size_q[j]};
    end
  end

  // lookup
  logic io_cyc;
  assign io_cyc = !lk_mem_i && (lk_addr_i[31:16] == 16'd0);

  logic            fix_hit;
  logic [1:0]      fix_idx;
  logic [NIO-1:0]  io_hitv;
  logic [NMEM-1:0] mem_hitv;
  logic            io_any, mem_any;
  logic [IDXW-1:0] io_idx, mem_idx;

  hcd_legacy_decode u_legacy (
    .io_i   (io_cyc),
    .addr_i (lk_addr_i[15:0]),
    .len_i  (lk_len_i),
    .en_i   (en_q[2:0]),
    .hit_o  (fix_hit),
    .idx_o  (fix_idx)
  );

  for (genvar gi = 0; gi < NIO; gi++) begin : g_io
    hcd_window_match #(.AW(16), .SW(8)) u_match (
      .en_i   (io_cyc && en_q[EN_IO_LSB + gi]),
      .addr_i (lk_addr_i[15:0]),
      .base_i (io_base_q[gi]),
      .size_i (io_size_q[gi]),
      .hit_o  (io_hitv[gi])
    );
  end

  for (genvar gj = 0; gj < NMEM; gj++) begin : g_mem
    hcd_window_match #(.AW(32), .SW(16)) u_match (
      .en_i   (lk_mem_i && en_q[EN_MEM_LSB + gj]),
      .addr_i (lk_addr_i),
      .base_i (mem_base_q[gj]),
      .size_i (mem_size_q[gj]),
      .hit_o  (mem_hitv[gj])
    );
  end

  hcd_lowest_pick #(.N(NIO), .IW(IDXW)) u_io_pick (
    .req_i (io_hitv), .any_o (io_any), .idx_o (io_idx)
  );
  hcd_lowest_pick #(.N(NMEM), .IW(IDXW)) u_mem_pick (
    .req_i (mem_hitv), .any_o (mem_any), .idx_o (mem_idx)
  );

  always_comb begin
    kind_o = HK_NONE;
    idx_o  = '0;
    if (fix_hit) begin
      kind_o = HK_FIXED;
      idx_o  = IDXW'(fix_idx);
    end else if (io_any) begin
      kind_o = HK_IO;
      idx_o  = io_idx;
    end else if (mem_any) begin
      kind_o = HK_MEM;
      idx_o  = mem_idx;
    end else if (sub_q) begin
      kind_o = HK_SUB;
    end
  end
  assign fwd_o = (kind_o != HK_NONE);

  // assertions
  a_r4_io_enabled_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == HK_IO) |-> en_q[EN_IO_LSB + 32'(idx_o)]);

  a_r8_lowest_io: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == HK_IO) |-> ((io_hitv & ((NIO'(1) << idx_o) - NIO'(1))) == '0));

  a_r2_fixed_io_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_o == HK_FIXED) |-> !lk_mem_i);

  a_r9_sub_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sub_q |-> (kind_o != HK_SUB));

  a_r6_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == OFF_EN && cfg_wdata_i == '0) |=> (en_q == '0));

  a_r7_set_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_addr_i == OFF_EN_SET) |=> ((en_q & $past(en_q)) == $past(en_q)));
endmodule

// File: tb/tb_host_cycle_decoder.sv
`timescale 1ns/1ps
module tb_host_cycle_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [31:0] lk_addr = '0;
  logic        lk_mem = 1'b0;
  logic [2:0]  lk_len = 3'd1;
  logic        fwd;
  logic [2:0]  kind;
  logic [1:0]  idx;

  always #2.5 clk = ~clk;

  host_cycle_decoder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .lk_addr_i(lk_addr), .lk_mem_i(lk_mem), .lk_len_i(lk_len),
    .fwd_o(fwd), .kind_o(kind), .idx_o(idx)
  );

  typedef struct {
    logic       fwd;
    logic [2:0] kind;
    logic [1:0] idx;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 0;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    cfg_addr = a;
    #1;
    n_chk++;
    if (cfg_rdata !== e) begin
      n_bad++;
      $display("FAIL %s reg 0x%02h: got 0x%08h exp 0x%08h", tag, a, cfg_rdata, e);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic m, input logic [2:0] l,
                      input logic [2:0] k, input logic [1:0] i, input string tag);
    exp_t e;
    @(posedge clk); #1;
    lk_addr = a; lk_mem = m; lk_len = l;
    e.fwd = (k != 3'd0); e.kind = k; e.idx = i; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (fwd !== e.fwd || kind !== e.kind || idx !== e.idx) begin
        n_bad++;
        $display("FAIL %s addr 0x%08h: got fwd=%0b kind=%0d idx=%0d exp fwd=%0b kind=%0d idx=%0d",
                 e.tag, lk_addr, fwd, kind, idx, e.fwd, e.kind, e.idx);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset
    look(32'h80, 0, 3'd1, 3'd0, 2'd0, "R1");
    rd(8'h00, 32'h0, "R1");
    rd(8'h40, 32'h0, "R1");

    // R2 fixed decodes
    wr(8'h04, 32'h7);
    look(32'h80, 0, 3'd1, 3'd1, 2'd0, "R2");
    look(32'h80, 0, 3'd2, 3'd0, 2'd0, "R2");
    look(32'h60, 0, 3'd1, 3'd1, 2'd1, "R2");
    look(32'h64, 0, 3'd1, 3'd1, 2'd1, "R2");
    look(32'h62, 0, 3'd1, 3'd0, 2'd0, "R2");
    look(32'h2F, 0, 3'd1, 3'd1, 2'd2, "R2");
    look(32'h2E, 0, 3'd2, 3'd1, 2'd2, "R2");
    look(32'h2F, 0, 3'd2, 3'd0, 2'd0, "R2");
    look(32'h80, 1, 3'd1, 3'd0, 2'd0, "R2");

    // R3/R4 io window 0
    wr(8'h40, 32'h000F_0400);
    look(32'h405, 0, 3'd1, 3'd0, 2'd0, "R4");
    wr(8'h04, 32'h100);
    rd(8'h00, 32'h107, "R7");
    look(32'h400, 0, 3'd1, 3'd2, 2'd0, "R3");
    look(32'h40F, 0, 3'd1, 3'd2, 2'd0, "R3");
    look(32'h410, 0, 3'd1, 3'd0, 2'd0, "R3");
    look(32'h3FF, 0, 3'd1, 3'd0, 2'd0, "R3");

    // R3 top of io space
    wr(8'h48, 32'h00FF_FFF0);
    wr(8'h04, 32'h400);
    look(32'hFFF0, 0, 3'd1, 3'd2, 2'd2, "R3");
    look(32'hFFFF, 0, 3'd1, 3'd2, 2'd2, "R3");
    look(32'h0001_0005, 0, 3'd1, 3'd0, 2'd0, "R3");
    look(32'h0005, 0, 3'd1, 3'd0, 2'd0, "R3");

    // R8 priority
    wr(8'h44, 32'h0003_0408);
    wr(8'h4C, 32'h0000_0080);
    wr(8'h04, 32'hA00);
    rd(8'h00, 32'hF07, "R7");
    look(32'h409, 0, 3'd1, 3'd2, 2'd0, "R8");
    look(32'h80, 0, 3'd1, 3'd1, 2'd0, "R8");
    look(32'h80, 0, 3'd2, 3'd2, 2'd3, "R8");

    // R5 memory windows
    wr(8'h88, 32'h1000_0000);
    wr(8'h8C, 32'h0000_FFFF);
    wr(8'h80, 32'hFFFF_FF00);
    wr(8'h84, 32'h0000_FFFF);
    wr(8'h04, 32'h3_0000);
    look(32'h1000_FFFF, 1, 3'd4, 3'd3, 2'd1, "R5");
    look(32'h1001_0000, 1, 3'd4, 3'd0, 2'd0, "R5");
    look(32'hFFFF_FFFF, 1, 3'd4, 3'd3, 2'd0, "R5");
    look(32'h0000_0010, 1, 3'd4, 3'd0, 2'd0, "R5");
    look(32'h0000_0400, 1, 3'd4, 3'd0, 2'd0, "R5");
    rd(8'h8C, 32'h0000_FFFF, "R10");
    rd(8'h44, 32'h0003_0408, "R10");

    // R9 subtractive
    wr(8'h08, 32'h1);
    rd(8'h08, 32'h1, "R10");
    look(32'h1234, 0, 3'd1, 3'd4, 2'd0, "R9");
    look(32'h2000_0000, 1, 3'd4, 3'd4, 2'd0, "R9");
    look(32'h400, 0, 3'd1, 3'd2, 2'd0, "R9");

    // R6 clear
    wr(8'h00, 32'h0);
    rd(8'h00, 32'h0, "R6");
    rd(8'h40, 32'h000F_0400, "R6");
    rd(8'h88, 32'h1000_0000, "R6");
    look(32'h400, 0, 3'd1, 3'd4, 2'd0, "R6");
    wr(8'h08, 32'h0);
    look(32'h400, 0, 3'd1, 3'd0, 2'd0, "R9");
    look(32'h1000_0000, 1, 3'd4, 3'd0, 2'd0, "R6");

    // direct write replaces
    wr(8'h00, 32'h4);
    look(32'h80, 0, 3'd1, 3'd0, 2'd0, "R6");
    look(32'h2E, 0, 3'd1, 3'd1, 2'd2, "R2");

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule